// File: doc/BRIEF.md
# Code-Density Bin-Width Calibrator

This block calibrates the fine interpolator of a time-to-digital converter from statistics. It is fed fine codes from hits whose timing is unrelated to the converter clock. Those hits land uniformly across one clock period, so a code that occurs more often than average marks a wider delay bin. One pulse on `start_i` latches a hit target and the clock period in picoseconds, then clears the histogram and all results. Every accepted fine code then increments its own saturating counter.

When the number of accepted hits reaches the target, the block stops collecting. A shared sequential divider then processes one code at a time, running two divisions per code:

- the bin width in picoseconds;
- the DNL in LSB, as signed fixed point with 8 fractional bits.

The INL is a running sum of the DNL values. After the last code, `done_o` rises and stays high. The three results for any code can then be read combinationally by placing its number on `rd_code_i`. Each device needs its own calibration run, because bin sizes differ from part to part.

Controller states:

- IDLE: after reset, nothing counted.
- COLLECT: counting hits.
- CALC_WIDTH: width division for the current code.
- CALC_DNL: DNL division for the current code.
- DONE: results held.

Transitions:

- *start*: any state to COLLECT.
- *target reached*: COLLECT to CALC_WIDTH.
- *width ready*: CALC_WIDTH to CALC_DNL.
- *next code*: CALC_DNL to CALC_WIDTH, when the current code is not the last.
- *last code*: CALC_DNL to DONE.

Top module: `code_density_cal`

## Requirements
- R1: A cycle with `start_i` high latches the target and the period, and clears the histogram, the hit total and every stored result to zero. In the next cycle `busy_o` is 1 and `done_o` is 0. A target of 0 is treated as 1.
- R2: Only a valid hit in COLLECT that arrives before the target is met, and not in a start cycle, increments the counter of its code (`hit_code_i` is the bin number). Hits in IDLE, CALC_WIDTH, CALC_DNL or DONE leave the results unchanged.
- R3: Collection ends when the total of accepted hits equals the target. Later hits are not counted, and the total never exceeds the target.
- R4: Each bin counter saturates at 2^CNT_W-1. Hits to a saturated bin still count toward the total.
- R5: The bin width of code k is floor(count_k × period / T), where T is the effective target. It never exceeds the period.
- R6: The DNL of code k is floor(count_k × 2^CODE_W × 256 / T) − 256, in two's complement with 8 fractional bits (256 = 1 LSB). It is never below −256.
- R7: The INL of code k is the sum of the DNL values of codes 0 to k.
- R8: `done_o` rises once every code has been processed. It stays high until the next start, and is never high together with `busy_o`.
- R9: `rd_width_o`, `rd_dnl_o` and `rd_inl_o` show the stored results of code `rd_code_i` within the same cycle.
- R10: A start during COLLECT, CALC_WIDTH or CALC_DNL abandons the run. The results then reflect only the hits after the last start.
- R11: After reset, `busy_o` and `done_o` are 0 and every readout is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start_i | input | 1 | begin a new calibration run |
| hit_valid_i | input | 1 | fine code strobe |
| hit_code_i | input | CODE_W | fine code of the hit |
| target_i | input | TOT_W | number of hits to collect |
| period_ps_i | input | PER_W | clock period in picoseconds |
| rd_code_i | input | CODE_W | code selected for readout |
| rd_width_o | output | PER_W | bin width in picoseconds |
| rd_dnl_o | output | CODE_W+10 | signed DNL, 8 fractional bits |
| rd_inl_o | output | CODE_W+10 | signed INL, 8 fractional bits |
| busy_o | output | 1 | collecting or computing |
| done_o | output | 1 | results valid |

## Verification
A miscounted bin shows at the ports in two ways once `done_o` rises. Its width and DNL are off, and because the INL is a running sum, the INL of that code and of every later code moves by the same amount. A hit accepted after the target, or during computation, breaks the identity that the DNL values sum to about zero, so the last INL entry departs from its expected value. A stale divider result or a wrong code index moves results between neighbouring codes, which the full sweep of every code after each run reports. An early or missing `done_o`, or `busy_o` after start, shows within one cycle.

// File: rtl/cal_pkg.sv
package cal_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_CALC_WIDTH,
        ST_CALC_DNL,
        ST_DONE
    } cal_state_t;

    localparam int FRAC_BITS = 8;
endpackage

// File: rtl/cal_hist_bank.sv
module cal_hist_bank #(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 20,
    parameter int TOT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              hit_en_i,
    input  logic [CODE_W-1:0] hit_code_i,
    input  logic [CODE_W-1:0] rd_idx_i,
    output logic [CNT_W-1:0]  rd_cnt_o,
    output logic [TOT_W-1:0]  total_o
);
    localparam int NBINS = 1 << CODE_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] bins_q [NBINS];
    logic [TOT_W-1:0] total_q;

    for (genvar b = 0; b < NBINS; b++) begin : g_bin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bins_q[b] <= '0;
            end else if (clear_i) begin
                bins_q[b] <= '0;
            end else if (hit_en_i && hit_code_i == CODE_W'(b) && bins_q[b] != CNT_MAX) begin
                bins_q[b] <= bins_q[b] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_q <= '0;
        end else if (clear_i) begin
            total_q <= '0;
        end else if (hit_en_i) begin
            total_q <= total_q + 1'b1;
        end
    end

    assign rd_cnt_o = bins_q[rd_idx_i];
    assign total_o  = total_q;
endmodule

// File: rtl/cal_seq_div.sv
module cal_seq_div #(
    parameter int DVD_W = 36,
    parameter int DVS_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort_i,
    input  logic             go_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic             done_o,
    output logic [DVD_W-1:0] quotient_o
);
    localparam int STEP_W = $clog2(DVD_W + 1);

    logic [DVS_W-1:0]  rem_q;
    logic [DVS_W-1:0]  dvs_q;
    logic [DVD_W-1:0]  sh_q;
    logic [STEP_W-1:0] left_q;
    logic              done_q;
    logic [DVS_W:0]    trial;
    logic              fits;

    always_comb begin
        trial = {rem_q, sh_q[DVD_W-1]};
        fits  = (trial >= {1'b0, dvs_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            dvs_q  <= '0;
            sh_q   <= '0;
            left_q <= '0;
            done_q <= 1'b0;
        end else if (abort_i) begin
            left_q <= '0;
            done_q <= 1'b0;
        end else if (go_i) begin
            rem_q  <= '0;
            dvs_q  <= divisor_i;
            sh_q   <= dividend_i;
            left_q <= STEP_W'(DVD_W);
            done_q <= 1'b0;
        end else if (left_q != '0) begin
            if (fits) begin
                rem_q <= DVS_W'(trial - {1'b0, dvs_q});
                sh_q  <= {sh_q[DVD_W-2:0], 1'b1};
            end else begin
                rem_q <= trial[DVS_W-1:0];
                sh_q  <= {sh_q[DVD_W-2:0], 1'b0};
            end
            left_q <= left_q - 1'b1;
            done_q <= (left_q == STEP_W'(1));
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done_o     = done_q;
    assign quotient_o = sh_q;
endmodule

// File: rtl/code_density_cal.sv
module code_density_cal
    import cal_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 20,
    parameter int TOT_W  = 24,
    parameter int PER_W  = 16
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    start_i,
    input  logic                                    hit_valid_i,
    input  logic [CODE_W-1:0]                       hit_code_i,
    input  logic [TOT_W-1:0]                        target_i,
    input  logic [PER_W-1:0]                        period_ps_i,
    input  logic [CODE_W-1:0]                       rd_code_i,
    output logic [PER_W-1:0]                        rd_width_o,
    output logic signed [CODE_W+FRAC_BITS+1:0]      rd_dnl_o,
    output logic signed [CODE_W+FRAC_BITS+1:0]      rd_inl_o,
    output logic                                    busy_o,
    output logic                                    done_o
);
    localparam int NBINS    = 1 << CODE_W;
    localparam int SCALE_SH = CODE_W + FRAC_BITS;
    localparam int FX_W     = SCALE_SH + 2;
    localparam int DVD_W    = (PER_W > SCALE_SH) ? CNT_W + PER_W : CNT_W + SCALE_SH;
    localparam logic signed [FX_W-1:0] ONE_LSB = FX_W'(1 << FRAC_BITS);
    localparam logic [DVD_W-1:0] DNL_QMAX = DVD_W'(NBINS) << FRAC_BITS;

    cal_state_t state_q, state_d;

    logic [TOT_W-1:0]       tgt_q;
    logic [PER_W-1:0]       per_q;
    logic [CODE_W-1:0]      idx_q;
    logic signed [FX_W-1:0] inl_acc_q;
    logic [PER_W-1:0]       width_q [NBINS];
    logic signed [FX_W-1:0] dnl_q   [NBINS];
    logic signed [FX_W-1:0] inl_q   [NBINS];

    logic [TOT_W-1:0]  total_w;
    logic [CNT_W-1:0]  bin_cnt;
    logic [CODE_W-1:0] bin_idx;
    logic              hit_en;
    logic              div_go, div_done;
    logic [DVD_W-1:0]  div_dvd, div_quo;
    logic              last_code;
    logic [PER_W-1:0]  width_new;
    logic [FX_W-1:0]   dnl_quo;
    logic signed [FX_W-1:0] dnl_new, inl_new;

    // histogram
    assign hit_en  = hit_valid_i && !start_i && (state_q == ST_COLLECT) && (total_w != tgt_q);
    assign bin_idx = (state_q == ST_CALC_DNL) ? idx_q + 1'b1 : idx_q;

    cal_hist_bank #(.CODE_W(CODE_W), .CNT_W(CNT_W), .TOT_W(TOT_W)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_i),
        .hit_en_i   (hit_en),
        .hit_code_i (hit_code_i),
        .rd_idx_i   (bin_idx),
        .rd_cnt_o   (bin_cnt),
        .total_o    (total_w)
    );

    // width division takes count*period, DNL division takes count scaled to LSB/256
    assign div_dvd = (state_q == ST_CALC_WIDTH)
                   ? (DVD_W'(bin_cnt) << SCALE_SH)
                   : DVD_W'(bin_cnt) * DVD_W'(per_q);

    cal_seq_div #(.DVD_W(DVD_W), .DVS_W(TOT_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort_i    (start_i),
        .go_i       (div_go),
        .dividend_i (div_dvd),
        .divisor_i  (tgt_q),
        .done_o     (div_done),
        .quotient_o (div_quo)
    );

    assign last_code = (idx_q == CODE_W'(NBINS - 1));
    assign width_new = (div_quo > DVD_W'(per_q)) ? per_q : div_quo[PER_W-1:0];
    assign dnl_quo   = (div_quo > DNL_QMAX) ? FX_W'(DNL_QMAX) : div_quo[FX_W-1:0];
    assign dnl_new   = $signed(dnl_quo) - ONE_LSB;
    assign inl_new   = inl_acc_q + dnl_new;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and divider launch
    always_comb begin
        state_d = state_q;
        div_go  = 1'b0;
        if (start_i) begin
            state_d = ST_COLLECT;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_COLLECT: begin
                    if (total_w == tgt_q) begin
                        state_d = ST_CALC_WIDTH;
                        div_go  = 1'b1;
                    end
                end
                ST_CALC_WIDTH: begin
                    if (div_done) begin
                        state_d = ST_CALC_DNL;
                        div_go  = 1'b1;
                    end
                end
                ST_CALC_DNL: begin
                    if (div_done) begin
                        if (last_code) begin
                            state_d = ST_DONE;
                        end else begin
                            state_d = ST_CALC_WIDTH;
                            div_go  = 1'b1;
                        end
                    end
                end
                ST_DONE: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // flags
    always_comb begin
        busy_o = (state_q == ST_COLLECT) || (state_q == ST_CALC_WIDTH) || (state_q == ST_CALC_DNL);
        done_o = (state_q == ST_DONE);
    end

    // run parameters and result store
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q     <= '0;
            per_q     <= '0;
            idx_q     <= '0;
            inl_acc_q <= '0;
            for (int k = 0; k < NBINS; k++) begin
                width_q[k] <= '0;
                dnl_q[k]   <= '0;
                inl_q[k]   <= '0;
            end
        end else if (start_i) begin
            tgt_q     <= (target_i == '0) ? TOT_W'(1) : target_i;
            per_q     <= period_ps_i;
            idx_q     <= '0;
            inl_acc_q <= '0;
            for (int k = 0; k < NBINS; k++) begin
                width_q[k] <= '0;
                dnl_q[k]   <= '0;
                inl_q[k]   <= '0;
            end
        end else begin
            if (state_q == ST_CALC_WIDTH && div_done) begin
                width_q[idx_q] <= width_new;
            end
            if (state_q == ST_CALC_DNL && div_done) begin
                dnl_q[idx_q] <= dnl_new;
                inl_q[idx_q] <= inl_new;
                inl_acc_q    <= inl_new;
                if (!last_code) idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign rd_width_o = width_q[rd_code_i];
    assign rd_dnl_o   = dnl_q[rd_code_i];
    assign rd_inl_o   = inl_q[rd_code_i];
endmodule

// File: rtl/code_density_cal_chk.sv
module code_density_cal_chk #(
    parameter int CODE_W = 4,
    parameter int TOT_W  = 24,
    parameter int PER_W  = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start_i,
    input logic                        busy_o,
    input logic                        done_o,
    input logic [CODE_W-1:0]           rd_code_i,
    input logic [PER_W-1:0]            rd_width_o,
    input logic signed [CODE_W+9:0]    rd_dnl_o,
    input logic signed [CODE_W+9:0]    rd_inl_o,
    input logic [TOT_W-1:0]            total_w,
    input logic [TOT_W-1:0]            tgt_q,
    input logic [PER_W-1:0]            per_q
);
    localparam int FX_W = CODE_W + 10;
    localparam logic signed [FX_W-1:0] NEG_LSB = -FX_W'(256);

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && !done_o)); // R1

    AST_TOTAL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        total_w <= tgt_q); // R3

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o)); // R8

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o); // R8

    AST_WIDTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rd_width_o <= per_q)); // R5

    AST_DNL_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rd_dnl_o >= NEG_LSB)); // R6

    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(done_o) && !$past(start_i) && $stable(rd_code_i))
        |-> ($stable(rd_width_o) && $stable(rd_dnl_o) && $stable(rd_inl_o))); // R2
endmodule

bind code_density_cal code_density_cal_chk #(
    .CODE_W (CODE_W),
    .TOT_W  (TOT_W),
    .PER_W  (PER_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rd_code_i  (rd_code_i),
    .rd_width_o (rd_width_o),
    .rd_dnl_o   (rd_dnl_o),
    .rd_inl_o   (rd_inl_o),
    .total_w    (total_w),
    .tgt_q      (tgt_q),
    .per_q      (per_q)
);

// File: tb/tb_code_density_cal.sv
module tb_code_density_cal;
    localparam int CODE_W = 3;
    localparam int CNT_W  = 6;
    localparam int TOT_W  = 10;
    localparam int PER_W  = 12;
    localparam int NB     = 1 << CODE_W;
    localparam int FX_W   = CODE_W + 10;
    localparam int SAT    = (1 << CNT_W) - 1;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start_i = 1'b0;
    logic                    hit_valid_i = 1'b0;
    logic [CODE_W-1:0]       hit_code_i = '0;
    logic [TOT_W-1:0]        target_i = '0;
    logic [PER_W-1:0]        period_ps_i = '0;
    logic [CODE_W-1:0]       rd_code_i = '0;
    logic [PER_W-1:0]        rd_width_o;
    logic signed [FX_W-1:0]  rd_dnl_o;
    logic signed [FX_W-1:0]  rd_inl_o;
    logic                    busy_o;
    logic                    done_o;

    int checks = 0;
    int fails  = 0;
    int mdl_cnt [NB];
    int mdl_tgt;
    int mdl_per;
    int mdl_acc;

    always #2 clk = ~clk;

    code_density_cal #(.CODE_W(CODE_W), .CNT_W(CNT_W), .TOT_W(TOT_W), .PER_W(PER_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .hit_valid_i(hit_valid_i),
        .hit_code_i(hit_code_i), .target_i(target_i), .period_ps_i(period_ps_i),
        .rd_code_i(rd_code_i), .rd_width_o(rd_width_o), .rd_dnl_o(rd_dnl_o),
        .rd_inl_o(rd_inl_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic start_run(input int tgt, input int per);
        @(negedge clk);
        start_i = 1'b1;
        target_i = TOT_W'(tgt);
        period_ps_i = PER_W'(per);
        @(negedge clk);
        start_i = 1'b0;
        mdl_tgt = (tgt == 0) ? 1 : tgt;
        mdl_per = per;
        mdl_acc = 0;
        for (int k = 0; k < NB; k++) mdl_cnt[k] = 0;
    endtask

    // drive one hit that is sampled while collecting
    task automatic send_hit(input int code);
        hit_valid_i = 1'b1;
        hit_code_i  = CODE_W'(code);
        if (mdl_acc < mdl_tgt) begin
            mdl_acc++;
            if (mdl_cnt[code] < SAT) mdl_cnt[code]++;
        end
        @(negedge clk);
        hit_valid_i = 1'b0;
    endtask

    // hit expected to be ignored: model untouched
    task automatic send_stray(input int code);
        hit_valid_i = 1'b1;
        hit_code_i  = CODE_W'(code);
        @(negedge clk);
        hit_valid_i = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n;
        n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check("R8", {tag, " done reached"}, longint'(done_o), 1);
        check("R8", {tag, " busy low when done"}, longint'(busy_o), 0);
    endtask

    task automatic check_results(input string tag);
        longint inl;
        inl = 0;
        for (int k = 0; k < NB; k++) begin
            longint w, d;
            w = (longint'(mdl_cnt[k]) * mdl_per) / mdl_tgt;
            d = (longint'(mdl_cnt[k]) * NB * 256) / mdl_tgt - 256;
            inl += d;
            rd_code_i = CODE_W'(k);
            #1;
            check("R5", {tag, " width"}, longint'(rd_width_o), w);
            check("R6", {tag, " dnl"}, longint'(rd_dnl_o), d);
            check("R7", {tag, " inl"}, longint'(rd_inl_o), inl);
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < NB; k++) mdl_cnt[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11", "busy after reset", longint'(busy_o), 0);
        check("R11", "done after reset", longint'(done_o), 0);
        for (int k = 0; k < NB; k += 5) begin
            rd_code_i = CODE_W'(k);
            #1;
            check("R11", "width after reset", longint'(rd_width_o), 0);
            check("R11", "inl after reset", longint'(rd_inl_o), 0);
        end
        // R2 hits in IDLE are ignored
        for (int i = 0; i < 4; i++) send_stray(1);
        check("R2", "busy in idle", longint'(busy_o), 0);

        // nonuniform, odd codes empty, extra hits past target ignored (R3)
        start_run(80, 1000);
        check("R1", "busy after start", longint'(busy_o), 1);
        check("R1", "done after start", longint'(done_o), 0);
        for (int i = 0; i < 85; i++) send_hit((i * i + 3 * i) % NB);
        wait_done("R3 nonuniform");
        check_results("R3 nonuniform");

        // R2 hits during DONE leave results unchanged
        for (int i = 0; i < 10; i++) send_stray(i % NB);
        check_results("R2 done-stray");

        // R1 start clears results
        start_run(64, 2000);
        rd_code_i = CODE_W'(0);
        #1;
        check("R1", "width cleared", longint'(rd_width_o), 0);
        check("R1", "dnl cleared", longint'(rd_dnl_o), 0);
        for (int i = 0; i < 64; i++) send_hit(i % NB);
        wait_done("R9 uniform");
        check_results("R9 uniform");

        // R4 saturation
        start_run(200, 1000);
        for (int i = 0; i < 200; i++) send_hit((i % 4 == 0) ? 5 : 2);
        wait_done("R4 saturate");
        check_results("R4 saturate");

        // R1 target zero behaves as one
        start_run(0, 800);
        send_hit(3);
        send_hit(4);
        wait_done("R1 zero target");
        check_results("R1 zero target");

        // R10 restart during collection
        start_run(40, 1500);
        for (int i = 0; i < 10; i++) send_hit(7);
        start_run(24, 1500);
        for (int i = 0; i < 24; i++) send_hit((i % 3 == 0) ? 6 : i % NB);
        wait_done("R10 restart collect");
        check_results("R10 restart collect");

        // R10 restart during computation, strays while computing (R2)
        start_run(16, 900);
        for (int i = 0; i < 16; i++) send_hit(1);
        for (int i = 0; i < 6; i++) send_stray(0);
        check("R10", "busy while computing", longint'(busy_o), 1);
        start_run(32, 900);
        for (int i = 0; i < 32; i++) send_hit((i * 7 + 2) % NB);
        wait_done("R10 restart compute");
        check_results("R10 restart compute");

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule